// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Generator

This block drives several PWM output pins that all run on one common period. A single free-running 8-bit tick counter, advanced by a programmable clock divider, is shared by every channel. Each channel compares that count with its own duty value. As a result, all outputs have the same period and are phase-aligned at the start of each period, while each has its own high time. The period is always 256 ticks. The only way to change it is the 8-bit divider setting, so one tick lasts (setting + 1) input clocks.

Software programs the block through a small 32-bit register port: a byte address, a write strobe, write data and combinational read data. Each channel has a duty register. A control register holds the divider setting, split across two nibbles, and one output enable that gates every pin at once. New duty and divider values are staged and take effect together at the next counter wrap, so a running period is never cut short. The asynchronous reset is released into the logic through a two-stage synchronizer.

Top module: `shared_pwm`

## Requirements
- R1: While reset is asserted, and until the second rising clock edge after `rst_n` rises, all outputs are low. After reset, every register reads back as zero.
- R2: The tick counter advances once every (divider + 1) clocks and wraps after 255, so the period is 256 × (divider + 1) clocks.
- R3: While enabled, channel n is high exactly while the tick count is less than or equal to its duty value, giving duty + 1 high ticks per period. The output is registered, so it trails the count by one clock.
- R4: A duty value of 0 gives a single-tick high pulse at the start of each period. A duty value of 255 gives a constant high level.
- R5: The control register sits at byte offset 0x50. The divider's low nibble is in bits [3:0], its high nibble is in bits [14:11], and the output enable is bit 9. It reads back these fields only, with every other bit reading zero.
- R6: The duty register of channel n is at byte offset 4·n and holds write-data bits [7:0]. Bits [31:8] read as zero.
- R7: While the output enable is clear, every output is low from the second clock edge after the write that cleared it.
- R8: Duty and divider writes are staged. They reach the outputs only at the clock edge where the counter wraps from 255 to 0. Readback always shows the staged value.
- R9: Writes to any other address, including misaligned ones, change nothing. Reads from such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data (combinational from `addr`) |
| pwm_out | output | 4 | One PWM pin per channel |

## Verification
The hardest case to reach is a duty or divider write that lands in the middle of a running period. In that case the old values must keep governing the pins for possibly thousands of clocks, and then switch over exactly at the wrap. The bench waits for a wrap, advances a fixed number of clocks into the next period, and then writes. It checks both the pin levels and a cycle-accurate model on every clock until and past the next wrap. A divider that uses both nibbles (value 18) is exercised by measuring the full 4864-clock period, from one rising edge to the next, on a channel programmed for the one-tick pulse.

// File: rtl/shared_pwm_pkg.sv
package shared_pwm_pkg;
  localparam int unsigned TICK_W     = 8;
  localparam int unsigned PSC_W      = 8;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned CTRL_ADDR  = 'h50;
  localparam int unsigned EN_BIT     = 9;
  localparam int unsigned PSC_LO_LSB = 0;
  localparam int unsigned PSC_HI_LSB = 11;

  typedef logic [TICK_W-1:0] tick_t;
  typedef logic [PSC_W-1:0]  psc_t;
endpackage

// File: rtl/spwm_rst_sync.sv
module spwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/spwm_regs.sv
module spwm_regs
  import shared_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [REG_W-1:0]               wr_data,
  input  logic                           wrap,
  output logic [REG_W-1:0]               rd_data,
  output logic [NUM_CH-1:0][TICK_W-1:0]  duty_act,
  output psc_t                           psc_act,
  output logic                           out_en
);
  localparam int unsigned STRIDE = 4;
  localparam int unsigned HALF   = PSC_W / 2;

  logic                          ctrl_hit;
  logic [NUM_CH-1:0]             duty_hit;
  logic [NUM_CH-1:0][TICK_W-1:0] duty_pend_q, duty_pend_d;
  psc_t                          psc_pend_q, psc_pend_d;
  logic                          out_en_d;
  logic                          unused_wdata;

  assign unused_wdata = ^wr_data;
  assign ctrl_hit     = (addr == ADDR_W'(CTRL_ADDR));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
    assign duty_hit[n] = (addr == ADDR_W'(STRIDE * n));
  end

  // next state of the staged (software-visible) copies
  always_comb begin
    duty_pend_d = duty_pend_q;
    psc_pend_d  = psc_pend_q;
    out_en_d    = out_en;
    if (wr_en) begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (duty_hit[n]) duty_pend_d[n] = wr_data[TICK_W-1:0];
      end
      if (ctrl_hit) begin
        psc_pend_d = {wr_data[PSC_HI_LSB +: HALF], wr_data[PSC_LO_LSB +: HALF]};
        out_en_d   = wr_data[EN_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_pend_q <= '0;
      psc_pend_q  <= '0;
      out_en      <= 1'b0;
    end else begin
      duty_pend_q <= duty_pend_d;
      psc_pend_q  <= psc_pend_d;
      out_en      <= out_en_d;
    end
  end

  // active copies: clock-enabled by the counter wrap only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_act <= '0;
      psc_act  <= '0;
    end else if (wrap) begin
      duty_act <= duty_pend_q;
      psc_act  <= psc_pend_q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (duty_hit[n]) rd_data[TICK_W-1:0] = duty_pend_q[n];
    end
    if (ctrl_hit) begin
      rd_data[PSC_LO_LSB +: HALF] = psc_pend_q[HALF-1:0];
      rd_data[PSC_HI_LSB +: HALF] = psc_pend_q[PSC_W-1:HALF];
      rd_data[EN_BIT]             = out_en;
    end
  end
endmodule

// File: rtl/spwm_timebase.sv
module spwm_timebase
  import shared_pwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  psc_t  psc_act,
  output tick_t cnt,
  output logic  tick,
  output logic  wrap
);
  psc_t  div_q, div_d;
  tick_t cnt_d;

  assign tick = (div_q == psc_act);
  assign wrap = tick && (cnt == '1);

  always_comb begin
    div_d = tick ? '0 : div_q + psc_t'(1);
    cnt_d = cnt + tick_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt   <= '0;
    end else begin
      div_q <= div_d;
      if (tick) cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/spwm_channel.sv
module spwm_channel
  import shared_pwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  tick_t cnt,
  input  tick_t duty,
  input  logic  out_en,
  output logic  pwm
);
  logic pwm_d;

  assign pwm_d = out_en && (cnt <= duty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm <= 1'b0;
    else        pwm <= pwm_d;
  end
endmodule

// File: rtl/shared_pwm.sv
module shared_pwm
  import shared_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [NUM_CH-1:0] pwm_out
);
  logic                          rst_sync_n;
  logic [NUM_CH-1:0][TICK_W-1:0] duty_act;
  psc_t                          psc_act;
  logic                          out_en;
  tick_t                         cnt;
  logic                          tick;
  logic                          wrap;

  spwm_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  spwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .wrap     (wrap),
    .rd_data  (rd_data),
    .duty_act (duty_act),
    .psc_act  (psc_act),
    .out_en   (out_en)
  );

  spwm_timebase i_timebase (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .psc_act (psc_act),
    .cnt     (cnt),
    .tick    (tick),
    .wrap    (wrap)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    spwm_channel i_channel (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .cnt    (cnt),
      .duty   (duty_act[n]),
      .out_en (out_en),
      .pwm    (pwm_out[n])
    );
  end
endmodule

// File: rtl/spwm_checker.sv
module spwm_checker
  import shared_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input tick_t                         cnt,
  input logic                          tick,
  input logic                          wrap,
  input logic [NUM_CH-1:0][TICK_W-1:0] duty_act,
  input psc_t                          psc_act,
  input logic                          out_en,
  input logic [NUM_CH-1:0]             pwm_out
);
  a_r2_count_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> (cnt == tick_t'($past(cnt) + tick_t'(1))));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  a_r3_period_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && cnt == '0) |=> (pwm_out == {NUM_CH{1'b1}}));

  a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> (pwm_out == '0));

  a_r8_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_act));

  a_r8_psc_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(psc_act));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_full
    a_r4_full_duty_high: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && duty_act[n] == '1) |=> pwm_out[n]);
  end
endmodule

bind shared_pwm spwm_checker #(.NUM_CH(NUM_CH)) i_checker (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cnt      (cnt),
  .tick     (tick),
  .wrap     (wrap),
  .duty_act (duty_act),
  .psc_act  (psc_act),
  .out_en   (out_en),
  .pwm_out  (pwm_out)
);

// File: tb/test_shared_pwm.sv
module test_shared_pwm;
  localparam int NUM_CH = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [7:0]        addr = '0;
  logic [31:0]       wr_data = '0;
  logic [31:0]       rd_data;
  logic [NUM_CH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  shared_pwm #(.NUM_CH(NUM_CH), .ADDR_W(8)) i_shared_pwm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pwm_out (pwm_out)
  );

  // ---------------- behavioural reference model ----------------
  int m_div, m_cnt, m_psc_act, m_psc_pend, m_en, m_rel, m_wraps;
  int m_duty_act [NUM_CH];
  int m_duty_pend[NUM_CH];
  logic [NUM_CH-1:0] m_out;
  bit m_tick, m_wrap;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_psc_act = 0; m_psc_pend = 0; m_en = 0;
      m_rel = 0; m_out = '0;
      foreach (m_duty_act[i]) begin m_duty_act[i] = 0; m_duty_pend[i] = 0; end
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      for (int i = 0; i < NUM_CH; i++) m_out[i] = (m_en != 0) && (m_cnt <= m_duty_act[i]);
      m_tick = (m_div == m_psc_act);
      m_wrap = m_tick && (m_cnt == 255);
      m_div  = m_tick ? 0 : m_div + 1;
      if (m_tick) m_cnt = (m_cnt + 1) % 256;
      if (m_wrap) begin
        m_psc_act = m_psc_pend;
        for (int i = 0; i < NUM_CH; i++) m_duty_act[i] = m_duty_pend[i];
        m_wraps++;
      end
      if (wr_en) begin
        if (addr == 8'h50) begin
          m_psc_pend = int'(wr_data[14:11]) * 16 + int'(wr_data[3:0]);
          m_en       = int'(wr_data[9]);
        end else begin
          for (int i = 0; i < NUM_CH; i++)
            if (addr == 8'(4 * i)) m_duty_pend[i] = int'(wr_data[7:0]);
        end
      end
    end
  end

  // per-clock comparison of every pin against the model
  always @(negedge clk) begin
    checks++;
    if (pwm_out !== m_out) begin
      errors++;
      $display("FAIL R3 R8 per-cycle pins at %0t actual=%b expected=%b", $time, pwm_out, m_out);
    end
  end

  // ---------------- tasks ----------------
  task automatic check_val(input int actual, input int expected, input string tag);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s read 0x%02h actual=0x%08h expected=0x%08h", tag, a, rd_data, exp);
    end
  endtask

  task automatic wait_wraps(input int k);
    int start;
    start = m_wraps;
    while (m_wraps < start + k) @(negedge clk);
  endtask

  task automatic measure_high(input int len, output int cnt[NUM_CH]);
    foreach (cnt[i]) cnt[i] = 0;
    repeat (len) begin
      @(negedge clk);
      for (int i = 0; i < NUM_CH; i++) cnt[i] += int'(pwm_out[i]);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (120000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=finished");
    report();
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int hi[NUM_CH];
    int period;

    repeat (3) @(negedge clk);
    check_val(int'(pwm_out), 0, "R1 pins in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_val(int'(pwm_out), 0, "R1 pins just after release");
    read_check(8'h00, 32'h0, "R1 duty0 reset");
    read_check(8'h0C, 32'h0, "R1 duty3 reset");
    read_check(8'h50, 32'h0, "R1 ctrl reset");

    // R3 R4 R6: four duty patterns, divider 0, enabled
    write_reg(8'h00, 32'h0000_0000);
    write_reg(8'h04, 32'h0000_0064);
    write_reg(8'h08, 32'h0000_00FF);
    write_reg(8'h0C, 32'hABCD_EF07);
    write_reg(8'h50, 32'h0000_0200);
    read_check(8'h04, 32'h0000_0064, "R6 duty1 readback");
    read_check(8'h0C, 32'h0000_0007, "R6 duty3 upper bits dropped");
    read_check(8'h50, 32'h0000_0200, "R5 ctrl enable readback");
    wait_wraps(1);
    measure_high(256, hi);
    check_val(hi[0], 1,   "R4 duty 0 single tick");
    check_val(hi[1], 101, "R3 duty 100 high ticks");
    check_val(hi[2], 256, "R4 duty 255 constant high");
    check_val(hi[3], 8,   "R3 duty 7 high ticks");

    // R5 R2: divider 18 split over both nibbles, junk in other bits
    write_reg(8'h50, 32'hFFFF_8FF2);
    read_check(8'h50, 32'h0000_0A02, "R5 ctrl field placement");
    wait_wraps(1);
    measure_high(4864, hi);
    check_val(hi[0], 19,   "R2 duty 0 with divider 18");
    check_val(hi[1], 1919, "R2 duty 100 with divider 18");
    check_val(hi[2], 4864, "R2 duty 255 with divider 18");
    check_val(hi[3], 152,  "R2 duty 7 with divider 18");
    // rise-to-rise interval on channel 0
    begin
      logic prev;
      prev = pwm_out[0];
      @(negedge clk);
      while (!(pwm_out[0] && !prev)) begin prev = pwm_out[0]; @(negedge clk); end
      period = 0;
      prev = pwm_out[0];
      @(negedge clk); period++;
      while (!(pwm_out[0] && !prev)) begin prev = pwm_out[0]; @(negedge clk); period++; end
      check_val(period, 4864, "R2 period in clocks");
    end

    // R8: mid-period writes are held until the wrap
    wait_wraps(1);
    repeat (100) @(negedge clk);
    write_reg(8'h08, 32'h0000_0000);
    write_reg(8'h50, 32'h0000_0200);
    repeat (3) @(negedge clk);
    check_val(int'(pwm_out[2]), 1, "R8 old duty still applied");
    read_check(8'h08, 32'h0, "R8 staged duty visible");
    wait_wraps(1);
    measure_high(256, hi);
    check_val(hi[2], 1,   "R8 new duty after wrap");
    check_val(hi[1], 101, "R8 new divider after wrap");

    // R7: global enable off
    write_reg(8'h50, 32'h0000_0000);
    measure_high(300, hi);
    for (int i = 0; i < NUM_CH; i++) check_val(hi[i], 0, "R7 disabled pins low");
    read_check(8'h50, 32'h0, "R7 enable cleared readback");
    write_reg(8'h50, 32'h0000_0200);

    // R9: unused and misaligned addresses
    write_reg(8'h10, 32'hFFFF_FFFF);
    write_reg(8'h4C, 32'hFFFF_FFFF);
    write_reg(8'h54, 32'hFFFF_FFFF);
    write_reg(8'h01, 32'hFFFF_FFFF);
    write_reg(8'h51, 32'hFFFF_FFFF);
    read_check(8'h10, 32'h0, "R9 unused read");
    read_check(8'h54, 32'h0, "R9 unused read");
    read_check(8'h01, 32'h0, "R9 misaligned read");
    read_check(8'h51, 32'h0, "R9 misaligned read");
    read_check(8'h00, 32'h0,          "R9 duty0 untouched");
    read_check(8'h04, 32'h0000_0064,  "R9 duty1 untouched");
    read_check(8'h0C, 32'h0000_0007,  "R9 duty3 untouched");
    read_check(8'h50, 32'h0000_0200,  "R9 ctrl untouched");
    wait_wraps(1);
    measure_high(256, hi);
    check_val(hi[1], 101, "R9 outputs unchanged");

    report();
    $finish;
  end
endmodule